// File: doc/BRIEF.md
# Token-Passing Counted Loop Controller

This block is a clocked control network assembled from single-step controllers that pass a one-cycle token. A controller wakes on a one-cycle start pulse and answers with a one-cycle finish pulse. Three composers join controllers. A chain wires one finish straight into the next start. A two-way choice steers the token by a condition and ORs the two finishes back together. A post-tested loop feeds the body finish back into the body start while its condition holds. The only leaf is a timed assignment. It takes one cycle and shows the newly stored value in the same cycle as its finish pulse.

A variable written by two separate leaves is kept as two private copies. A combiner selects the copy whose write-notify pulse is active, and otherwise it keeps the last combined value. The program built here clears a counter, then repeats a body until the counter reaches `LIMIT`. The body first updates an accumulator through a parity-steered choice and then increments the counter. Both the counter and the accumulator use a combiner. A caller pulses `go`, waits for `done` and reads the results.

Top module: `sfn_counted_loop`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, `done`, `count` and `acc` are all 0.
- R2: In the cycle after a `go` pulse, `count` reads 0 whatever value it held before.
- R3: Every timed assignment finishes exactly one cycle after its start, so each loop pass takes two cycles: `acc` changes one cycle after the choice starts, and `count` changes one cycle after that.
- R4: A pass whose `count` is odd sets `acc` to `acc + count` mod 2^W. A pass whose `count` is even sets `acc` to `acc XOR k`, with `k` sampled in the cycle that pass begins.
- R5: The body always runs at least once. After each increment it runs again only if `count < LIMIT`, so when `done` is high `count` equals `LIMIT`.
- R6: `done` is a one-cycle pulse that comes exactly 2*LIMIT+1 cycles after the `go` pulse. A new `go` is allowed only after `done` has been seen.
- R7: When no leaf writes them, `count` and `acc` hold their values. This includes the idle time between runs. A new `go` does not clear `acc`.
- R8: Each combined variable shows the value of whichever copy was just written. Its two copies are never written in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| go | input | 1 | One-cycle start pulse for a run |
| k | input | W | Operand XORed into `acc` on even passes |
| done | output | 1 | One-cycle finish pulse of the run |
| count | output | W | Combined loop counter |
| acc | output | W | Combined accumulator |

## Verification
The case hardest to reach from the ports is a combined variable holding steady across long stretches with no write, including the gap between runs, while its two copies keep stale values of their own. The stimulus runs several programs back to back with different `k` values and leaves idle gaps between them. A reference model, advanced every clock, predicts `count`, `acc` and `done` in every cycle, so a combiner that picks the wrong copy or forgets its held value shows up as a mismatch.

// File: rtl/sfn_pkg.sv
package sfn_pkg;
    localparam int DEF_WIDTH = 8;
    localparam int DEF_LIMIT = 5;

    // one pass costs a choice step plus an increment step
    localparam int STEPS_PER_PASS = 2;

    function automatic int run_latency(input int limit);
        return STEPS_PER_PASS * limit + 1;
    endfunction
endpackage

// File: rtl/sfn_assign.sv
// Timed assignment leaf: one-cycle step, new value visible with finish.
module sfn_assign #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] expr,
    output logic         fin,
    output logic [W-1:0] copy
);
    typedef struct packed {
        logic         fin;
        logic [W-1:0] val;
    } leaf_t;

    leaf_t leaf_d, leaf_q;

    always_comb begin
        leaf_d     = leaf_q;
        leaf_d.fin = start;
        if (start) begin
            leaf_d.val = expr;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            leaf_q <= '0;
        end else begin
            leaf_q <= leaf_d;
        end
    end

    assign fin  = leaf_q.fin;
    assign copy = leaf_q.val;

    // R3: finish follows start by exactly one cycle
    a_r3_fin_follows: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> fin);
    a_r3_fin_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> $past(start));
    a_r3_not_same_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !(start && fin));
endmodule

// File: rtl/sfn_merge.sv
// Combines two private copies of one variable using their write notifies.
module sfn_merge #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         note_a,
    input  logic [W-1:0] val_a,
    input  logic         note_b,
    input  logic [W-1:0] val_b,
    output logic [W-1:0] merged
);
    typedef struct packed {
        logic [W-1:0] held;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        if (note_a) begin
            merged = val_a;
        end else if (note_b) begin
            merged = val_b;
        end else begin
            merged = hold_q.held;
        end
        hold_d.held = merged;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q <= '0;
        end else begin
            hold_q <= hold_d;
        end
    end

    // R8: the two copies are never written together
    a_r8_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({note_a, note_b}));
    // R7: without a write the combined value stays put
    a_r7_hold_when_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(note_a || note_b) |-> $stable(merged));
endmodule

// File: rtl/sfn_choice.sv
// Two-way choice composer: steers the token, ORs the finishes.
module sfn_choice (
    input  logic start,
    input  logic cond,
    output logic start_yes,
    output logic start_no,
    input  logic fin_yes,
    input  logic fin_no,
    output logic fin
);
    always_comb begin
        start_yes = start & cond;
        start_no  = start & ~cond;
        fin       = fin_yes | fin_no;
    end
endmodule

// File: rtl/sfn_repeat.sv
// Post-tested loop composer: body reruns while cond holds at body finish.
module sfn_repeat (
    input  logic start,
    input  logic cond,
    input  logic body_fin,
    output logic body_start,
    output logic fin
);
    always_comb begin
        body_start = start | (body_fin & cond);
        fin        = body_fin & ~cond;
    end
endmodule

// File: rtl/sfn_counted_loop.sv
module sfn_counted_loop #(
    parameter int W     = sfn_pkg::DEF_WIDTH,
    parameter int LIMIT = sfn_pkg::DEF_LIMIT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] k,
    output logic         done,
    output logic [W-1:0] count,
    output logic [W-1:0] acc
);
    localparam logic [W-1:0] LIM_W = W'(LIMIT);

    // control tokens
    logic         init_fin, body_start, odd_start, even_start;
    logic         odd_fin, even_fin, choice_fin, inc_fin, keep_going;
    // private copies
    logic [W-1:0] cnt_init, cnt_inc, acc_odd, acc_even;

    typedef struct packed {
        logic busy;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // step 1 of the chain: clear the counter
    sfn_assign #(.W(W)) u_init (
        .clk(clk), .rst_n(rst_n), .start(go), .expr('0),
        .fin(init_fin), .copy(cnt_init)
    );

    assign keep_going = (count < LIM_W);

    // step 2 of the chain: the loop, started by the clear's finish
    sfn_repeat u_loop (
        .start(init_fin), .cond(keep_going), .body_fin(inc_fin),
        .body_start(body_start), .fin(done)
    );

    // loop body, first part: parity-steered accumulator update
    sfn_choice u_choice (
        .start(body_start), .cond(count[0]),
        .start_yes(odd_start), .start_no(even_start),
        .fin_yes(odd_fin), .fin_no(even_fin), .fin(choice_fin)
    );

    sfn_assign #(.W(W)) u_odd (
        .clk(clk), .rst_n(rst_n), .start(odd_start), .expr(acc + count),
        .fin(odd_fin), .copy(acc_odd)
    );

    sfn_assign #(.W(W)) u_even (
        .clk(clk), .rst_n(rst_n), .start(even_start), .expr(acc ^ k),
        .fin(even_fin), .copy(acc_even)
    );

    // loop body, second part: increment, started by the choice's finish
    sfn_assign #(.W(W)) u_inc (
        .clk(clk), .rst_n(rst_n), .start(choice_fin), .expr(count + 1'b1),
        .fin(inc_fin), .copy(cnt_inc)
    );

    sfn_merge #(.W(W)) u_cnt_merge (
        .clk(clk), .rst_n(rst_n),
        .note_a(init_fin), .val_a(cnt_init),
        .note_b(inc_fin), .val_b(cnt_inc),
        .merged(count)
    );

    sfn_merge #(.W(W)) u_acc_merge (
        .clk(clk), .rst_n(rst_n),
        .note_a(odd_fin), .val_a(acc_odd),
        .note_b(even_fin), .val_b(acc_even),
        .merged(acc)
    );

    always_comb begin
        ctl_d = ctl_q;
        if (go) begin
            ctl_d.busy = 1'b1;
        end else if (done) begin
            ctl_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    // R6: no new run before the previous finish was seen
    a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !ctl_q.busy);
    a_r6_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r6_done_in_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ctl_q.busy);
    // R5: loop exits only at the limit
    a_r5_exit_at_limit: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (count == LIM_W));
    // R2: the counter is cleared one cycle after go
    a_r2_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (count == '0));
    // R4: the choice always completes one cycle after entry
    a_r4_choice_step: assert property (@(posedge clk) disable iff (!rst_n)
        body_start |=> choice_fin);
endmodule

// File: tb/sfn_counted_loop_test.sv
module sfn_counted_loop_test;
    localparam int W   = 8;
    localparam int LIM = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         go = 1'b0;
    logic [W-1:0] k = '0;
    logic         done;
    logic [W-1:0] count, acc;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    sfn_counted_loop #(.W(W), .LIMIT(LIM)) uut (
        .clk(clk), .rst_n(rst_n), .go(go), .k(k),
        .done(done), .count(count), .acc(acc)
    );

    // behavioural reference: 0 idle, 1 choice pending, 2 increment pending
    int           m_state = 0;
    logic [W-1:0] m_i = '0;
    logic [W-1:0] m_acc = '0;
    logic         m_done = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_state = 0; m_i = '0; m_acc = '0; m_done = 1'b0;
        end else begin
            m_done = 1'b0;
            case (m_state)
                0: if (go) begin m_i = '0; m_state = 1; end
                1: begin
                    if (m_i % 2 == 1) m_acc = m_acc + m_i;
                    else              m_acc = m_acc ^ k;
                    m_state = 2;
                end
                default: begin
                    m_i = m_i + 1;
                    if (m_i < LIM) m_state = 1;
                    else begin m_state = 0; m_done = 1'b1; end
                end
            endcase
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // cycle-by-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            check(done == m_done, "R6 done", done, m_done);
            check(count == m_i, "R5,R8 count", count, m_i);
            check(acc == m_acc, "R3,R4,R8 acc", acc, m_acc);
        end
    end

    task automatic run(input logic [W-1:0] kv, output bit hung);
        int cyc = 0;
        hung = 1'b0;
        @(negedge clk);
        k  = kv;
        go = 1'b1;
        @(negedge clk);
        go  = 1'b0;
        cyc = 1;
        check(count == '0, "R2 cleared", count, 0);
        while (!done && cyc < 1000) begin
            @(negedge clk);
            cyc++;
        end
        if (cyc >= 1000) begin
            hung = 1'b1;
            check(1'b0, "watchdog", cyc, 2 * LIM + 1);
        end else begin
            check(cyc == 2 * LIM + 1, "R6 latency", cyc, 2 * LIM + 1);
            check(count == LIM, "R5 final count", count, LIM);
        end
        @(negedge clk);
        check(done == 1'b0, "R6 one-cycle pulse", done, 0);
    endtask

    initial begin
        bit hung;
        logic [W-1:0] snap;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(done == 1'b0 && count == '0 && acc == '0, "R1 in reset", acc, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(done == 1'b0 && count == '0 && acc == '0, "R1 after reset", count, 0);

        run(8'h5A, hung);
        // R7: idle gap leaves both variables unchanged
        snap = acc;
        repeat (7) @(negedge clk);
        check(acc == snap, "R7 acc idle hold", acc, snap);
        check(count == LIM, "R7 count idle hold", count, LIM);

        if (!hung) run(8'hFF, hung);
        if (!hung) run(8'h00, hung);
        if (!hung) run(8'h3C, hung);
        snap = acc;
        if (!hung) run(8'h81, hung);
        // R7: acc carried over, not cleared by go (XOR first pass on acc seen by model)
        check(snap != 8'h00 || acc == m_acc, "R7 acc carried", acc, m_acc);
        repeat (3) @(negedge clk);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1000000;
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule